// File: doc/BRIEF.md
# Multi-Page-Size Direct-Mapped Translation Buffer

This block caches virtual-to-physical translations for a 32-bit address space. It does not use one associative array. It keeps four independent direct-mapped stores, one for each page granularity: 1 MB sections, 64 KB large pages, 4 KB small pages and 1 KB tiny pages. Every cycle the presented virtual address is looked up in all four stores at once. The results are merged so that the smallest matching page wins. One clock later the block returns a registered hit flag, the translated physical address, the winning entry's attribute bits (access permission and cacheability) and the size class that produced the hit.

An external page-table walker fills the stores through an install port. Each install names a size class and writes only the store for that class, at the slot selected by the low virtual page number bits of that size. A flush input drops every entry in a single cycle. Instruction-side and data-side translation use two separate instances of this block, and the two share no state.

Top module: `tlb_multisize`

## Requirements
- R1: While reset is asserted and after it is released, every entry in all four stores is invalid, and `hit_o`, `pa_o`, `attr_o` and `size_o` are all zero.
- R2: The size code is 0 for 1 MB, 1 for 64 KB, 2 for 4 KB and 3 for 1 KB, with page offset widths of 20, 16, 12 and 10 bits. An install marks the entry valid in the store for `ins_size`, at the index taken from the virtual page number bits just above the offset (log2 of that store's depth bits). The full remaining upper virtual bits are kept as the tag.
- R3: Outputs are registered. The result for a lookup address presented in one cycle appears after the next rising clock edge.
- R4: On a hit, `pa_o` joins the installed physical frame, which is `ins_pa` above the offset width of the hitting size, with the offset bits of the lookup address.
- R5: A lookup misses when the indexed slot is invalid or when its stored tag differs from the lookup address's upper bits.
- R6: An install overwrites whatever entry already occupies the same slot of the same store.
- R7: When several stores hit, the smallest page size wins, and `size_o` reports its size code.
- R8: A flush invalidates all entries in all stores. A lookup presented in the same cycle as a flush reports a miss.
- R9: On a miss, `pa_o`, `attr_o` and `size_o` are zero.
- R10: An install into one size class leaves the entries of the other three classes unchanged.
- R11: On a hit, `attr_o` returns the attribute bits given with the winning entry's install.
- R12: When a flush and an install occur in the same cycle, the flush wins and the installed entry is not valid afterwards.
- R13: A lookup in the same cycle as an install sees the store contents from before that install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate, sampled every cycle |
| flush | input | 1 | Invalidate all entries |
| ins_en | input | 1 | Install request |
| ins_size | input | 2 | Size class of the install (0=1MB, 1=64KB, 2=4KB, 3=1KB) |
| ins_va | input | 32 | Virtual address of the installed page |
| ins_pa | input | 32 | Physical address of the installed page (frame bits used) |
| ins_attr | input | ATTR_W | Access-permission and cacheability bits to store |
| hit_o | output | 1 | Registered translation hit |
| pa_o | output | 32 | Registered physical address, zero on miss |
| attr_o | output | ATTR_W | Registered attributes of the winning entry, zero on miss |
| size_o | output | 2 | Size code of the winning entry, zero on miss |

## Verification
A corrupted valid bit or tag shows up one cycle after the next lookup that indexes the damaged slot. It appears either as a hit with a stale frame in `pa_o` or as a miss where a hit was expected. A wrong priority or a wrong index slice appears only when addresses overlap across size classes or collide within one store. For that reason the random stimulus reuses a small pool of page addresses and varies only their offsets. A flush that clears too little leaves `hit_o` high two cycles after the flush pulse.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned NUM_SIZES = 4;
    localparam int unsigned VA_W      = 32;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } pg_size_e;

    // Width of the byte offset inside a page of the given size class.
    function automatic int unsigned pg_offs(input int unsigned s);
        case (s)
            0:       return 20;
            1:       return 16;
            2:       return 12;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank #(
    parameter int unsigned OFFS_W = 12,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ATTR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    wr_en,
    input  logic [31-OFFS_W:0]      wr_vpn,
    input  logic [31-OFFS_W:0]      wr_frm,
    input  logic [ATTR_W-1:0]       wr_attr,
    input  logic [31:0]             rd_va,
    output logic                    rd_hit,
    output logic [31:0]             rd_pa,
    output logic [ATTR_W-1:0]       rd_attr
);
    localparam int unsigned FRM_W = 32 - OFFS_W;
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned TAG_W = FRM_W - IDX_W;

    logic [DEPTH-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [FRM_W-1:0]  frm_q  [DEPTH];
    logic [ATTR_W-1:0] attr_q [DEPTH];

    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  rd_tag;

    assign wr_idx = wr_vpn[IDX_W-1:0];
    assign rd_idx = rd_va[OFFS_W +: IDX_W];
    assign rd_tag = rd_va[31 -: TAG_W];

    // Valid bits: flush has priority over a same-cycle install.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Payload arrays carry no reset; the valid bit guards every read.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_idx]  <= wr_vpn[FRM_W-1:IDX_W];
            frm_q[wr_idx]  <= wr_frm;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    always_comb begin
        rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_pa   = '0;
        rd_attr = '0;
        if (rd_hit) begin
            rd_pa   = {frm_q[rd_idx], rd_va[OFFS_W-1:0]};
            rd_attr = attr_q[rd_idx];
        end
    end

endmodule

// File: rtl/tlb_merge.sv
module tlb_merge #(
    parameter int unsigned N      = 4,
    parameter int unsigned ATTR_W = 4,
    localparam int unsigned SEL_W = $clog2(N)
) (
    input  logic [N-1:0]      hit,
    input  logic [31:0]       pa   [N],
    input  logic [ATTR_W-1:0] attr [N],
    output logic              any_hit,
    output logic [31:0]       sel_pa,
    output logic [ATTR_W-1:0] sel_attr,
    output logic [SEL_W-1:0]  sel_idx
);
    // Higher index means smaller page; later matches override earlier.
    always_comb begin
        any_hit  = 1'b0;
        sel_pa   = '0;
        sel_attr = '0;
        sel_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                any_hit  = 1'b1;
                sel_pa   = pa[i];
                sel_attr = attr[i];
                sel_idx  = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize #(
    parameter int unsigned DEPTH_SEC = 4,
    parameter int unsigned DEPTH_LRG = 8,
    parameter int unsigned DEPTH_SML = 16,
    parameter int unsigned DEPTH_TNY = 32,
    parameter int unsigned ATTR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lk_va,
    input  logic              flush,
    input  logic              ins_en,
    input  logic [1:0]        ins_size,
    input  logic [31:0]       ins_va,
    input  logic [31:0]       ins_pa,
    input  logic [ATTR_W-1:0] ins_attr,
    output logic              hit_o,
    output logic [31:0]       pa_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic [1:0]        size_o
);
    import tlb_pkg::*;

    logic [NUM_SIZES-1:0] bank_hit;
    logic [31:0]          bank_pa   [NUM_SIZES];
    logic [ATTR_W-1:0]    bank_attr [NUM_SIZES];

    logic                 any_hit;
    logic [31:0]          win_pa;
    logic [ATTR_W-1:0]    win_attr;
    logic [1:0]           win_idx;
    logic                 live_hit;

    // Offset bits of the install addresses are never stored.
    logic unused_offs;
    assign unused_offs = ^{ins_va[9:0], ins_pa[9:0]};

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
        localparam int unsigned OW  = pg_offs(s);
        localparam int unsigned DEP = (s == 0) ? DEPTH_SEC :
                                      (s == 1) ? DEPTH_LRG :
                                      (s == 2) ? DEPTH_SML : DEPTH_TNY;
        logic sel_wr;
        assign sel_wr = ins_en && (ins_size == 2'(s));

        tlb_bank #(
            .OFFS_W (OW),
            .DEPTH  (DEP),
            .ATTR_W (ATTR_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .wr_en   (sel_wr),
            .wr_vpn  (ins_va[31:OW]),
            .wr_frm  (ins_pa[31:OW]),
            .wr_attr (ins_attr),
            .rd_va   (lk_va),
            .rd_hit  (bank_hit[s]),
            .rd_pa   (bank_pa[s]),
            .rd_attr (bank_attr[s])
        );
    end

    tlb_merge #(
        .N      (NUM_SIZES),
        .ATTR_W (ATTR_W)
    ) u_merge (
        .hit      (bank_hit),
        .pa       (bank_pa),
        .attr     (bank_attr),
        .any_hit  (any_hit),
        .sel_pa   (win_pa),
        .sel_attr (win_attr),
        .sel_idx  (win_idx)
    );

    assign live_hit = any_hit && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_o  <= 1'b0;
            pa_o   <= '0;
            attr_o <= '0;
            size_o <= '0;
        end else begin
            hit_o  <= live_hit;
            pa_o   <= live_hit ? win_pa   : '0;
            attr_o <= live_hit ? win_attr : '0;
            size_o <= live_hit ? win_idx  : '0;
        end
    end

endmodule

// File: rtl/tlb_multisize_chk.sv
module tlb_multisize_chk #(
    parameter int unsigned ATTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       lk_va,
    input logic              flush,
    input logic              hit_o,
    input logic [31:0]       pa_o,
    input logic [ATTR_W-1:0] attr_o,
    input logic [1:0]        size_o
);
    logic unused_hi;
    assign unused_hi = ^lk_va[31:20];

    // R8: lookup coinciding with flush reports a miss
    assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit_o);

    // R8: the lookup right after a flush finds every store empty
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ##2 !hit_o);

    // R9: miss drives zeros on every result field
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (pa_o == 32'd0 && attr_o == '0 && size_o == 2'd0));

    // R4: the smallest offset is always carried through from the lookup address
    assert_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> pa_o[9:0] == $past(lk_va[9:0]));

    // R4: a section hit keeps the full 20-bit offset
    assert_sec_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && size_o == 2'd0) |-> pa_o[19:0] == $past(lk_va[19:0]));

endmodule

bind tlb_multisize tlb_multisize_chk #(.ATTR_W(ATTR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_va  (lk_va),
    .flush  (flush),
    .hit_o  (hit_o),
    .pa_o   (pa_o),
    .attr_o (attr_o),
    .size_o (size_o)
);

// File: tb/sim_tlb_multisize.sv
`timescale 1ns/1ps
module sim_tlb_multisize;

    localparam int ATTR_W = 4;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       lk_va = '0;
    logic              flush = 1'b0;
    logic              ins_en = 1'b0;
    logic [1:0]        ins_size = '0;
    logic [31:0]       ins_va = '0;
    logic [31:0]       ins_pa = '0;
    logic [ATTR_W-1:0] ins_attr = '0;
    logic              hit_o;
    logic [31:0]       pa_o;
    logic [ATTR_W-1:0] attr_o;
    logic [1:0]        size_o;

    always #2 clk = ~clk;

    tlb_multisize #(.ATTR_W(ATTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .flush(flush),
        .ins_en(ins_en), .ins_size(ins_size), .ins_va(ins_va),
        .ins_pa(ins_pa), .ins_attr(ins_attr), .hit_o(hit_o),
        .pa_o(pa_o), .attr_o(attr_o), .size_o(size_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model: per size class, one slot array.
    bit          m_vld [4][32];
    logic [31:0] m_vpn [4][32];
    logic [31:0] m_frm [4][32];
    logic [3:0]  m_at  [4][32];

    function automatic int offs_of(int s);
        return (s == 0) ? 20 : (s == 1) ? 16 : (s == 2) ? 12 : 10;
    endfunction
    function automatic int depth_of(int s);
        return (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 16 : 32;
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 32; i++) m_vld[s][i] = 1'b0;
    endfunction

    // One cycle: drive at negedge, predict from pre-edge model, compare at next negedge.
    task automatic cyc(input logic [31:0] va, input bit fl, input bit ie,
                       input int sz, input logic [31:0] iva, input logic [31:0] ipa,
                       input logic [3:0] iat, input string req);
        bit          e_hit = 1'b0;
        logic [31:0] e_pa = '0;
        logic [3:0]  e_at = '0;
        logic [1:0]  e_sz = '0;
        lk_va = va; flush = fl; ins_en = ie; ins_size = 2'(sz);
        ins_va = iva; ins_pa = ipa; ins_attr = iat;
        for (int s = 0; s < 4; s++) begin
            int o = offs_of(s);
            logic [31:0] vpn = va >> o;
            int idx = int'(vpn % depth_of(s));
            if (m_vld[s][idx] && m_vpn[s][idx] == vpn) begin
                e_hit = 1'b1;
                e_pa  = (m_frm[s][idx] << o) | (va & ((32'h1 << o) - 1));
                e_at  = m_at[s][idx];
                e_sz  = 2'(s);
            end
        end
        if (fl) begin e_hit = 1'b0; e_pa = '0; e_at = '0; e_sz = '0; end
        @(posedge clk);
        if (fl) model_clear();
        else if (ie) begin
            int o = offs_of(sz);
            logic [31:0] vpn = iva >> o;
            int idx = int'(vpn % depth_of(sz));
            m_vld[sz][idx] = 1'b1;
            m_vpn[sz][idx] = vpn;
            m_frm[sz][idx] = ipa >> o;
            m_at[sz][idx]  = iat;
        end
        @(negedge clk);
        checks++;
        if (hit_o !== e_hit || pa_o !== e_pa || attr_o !== e_at || size_o !== e_sz) begin
            errors++;
            $display("FAIL %s: got hit=%0d pa=%h attr=%h size=%0d, expected hit=%0d pa=%h attr=%h size=%0d",
                     req, hit_o, pa_o, attr_o, size_o, e_hit, e_pa, e_at, e_sz);
        end
    endtask

    task automatic look(input logic [31:0] va, input string req);
        cyc(va, 1'b0, 1'b0, 0, 32'h0, 32'h0, 4'h0, req);
    endtask
    task automatic put(input int sz, input logic [31:0] iva, input logic [31:0] ipa,
                       input logic [3:0] iat, input string req);
        cyc(32'h0, 1'b0, 1'b1, sz, iva, ipa, iat, req);
    endtask

    initial begin
        #(WATCHDOG * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pool [8];
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        checks++;
        if (hit_o !== 1'b0 || pa_o !== '0 || attr_o !== '0 || size_o !== '0) begin
            errors++;
            $display("FAIL R1: got hit=%0d pa=%h, expected all zero during reset", hit_o, pa_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        look(32'h1234_5678, "R1 empty after reset");

        // Small page install, then offset join and attributes.
        put(2, 32'h1234_5000, 32'hABCD_E000, 4'h5, "R2 install small");
        look(32'h1234_5678, "R2 R4 R11 small hit");
        look(32'h1234_6678, "R5 other index");
        look(32'h2234_5678, "R5 tag mismatch");
        // Section overlapping the small page: smaller page wins.
        put(0, 32'h1230_0000, 32'h8000_0000, 4'h1, "R10 install section");
        look(32'h1234_5678, "R7 R10 small beats section");
        look(32'h123F_0001, "R4 section offset");
        // Tiny page inside the same range wins over both.
        put(3, 32'h1234_5400, 32'h0000_0C00, 4'hA, "R2 install tiny");
        look(32'h1234_5678, "R7 tiny wins");
        look(32'h1234_5078, "R7 small still wins below tiny");
        put(1, 32'h1234_0000, 32'h7700_0000, 4'h3, "R10 install large");
        look(32'h1234_F000, "R7 R3 large over section");
        // Overwrite a small slot with a different tag.
        put(2, 32'h2234_5000, 32'h5555_5000, 4'h7, "R6 overwrite");
        look(32'h2234_5ABC, "R6 new entry");
        look(32'h1234_5078, "R6 old entry gone");
        // Lookup during install sees old contents.
        cyc(32'h3333_3333, 1'b0, 1'b1, 3, 32'h3333_3000, 32'h4444_4000, 4'h2, "R13 same cycle");
        look(32'h3333_3333, "R13 visible next");
        // Flush with a lookup in the same cycle.
        cyc(32'h3333_3333, 1'b1, 1'b0, 0, 32'h0, 32'h0, 4'h0, "R8 flush lookup");
        look(32'h2234_5ABC, "R8 cleared");
        look(32'h123F_0001, "R8 cleared section");
        // Flush and install together.
        cyc(32'h0, 1'b1, 1'b1, 2, 32'h0BAD_F000, 32'h1111_1000, 4'hF, "R12 flush install");
        look(32'h0BAD_F123, "R12 not installed");

        // Random phase over a reused address pool.
        for (int k = 0; k < 8; k++) pool[k] = $urandom;
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(7));
            int act = int'($urandom_range(99));
            logic [31:0] va = pool[int'($urandom_range(7))] ^ ($urandom & 32'h0000_03FF);
            if (n % 300 == 299) pool[r] = $urandom;
            if (act < 2)
                cyc(va, 1'b1, 1'b0, 0, 32'h0, 32'h0, 4'h0, "R8 random flush");
            else if (act < 40)
                cyc(va, 1'b0, 1'b1, int'($urandom_range(3)), pool[r], $urandom,
                    4'($urandom), "R2 R6 R13 random install");
            else
                look(va, "R4 R7 R11 random lookup");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule